// File: doc/BRIEF.md
# Read-Modify-Write Memory Operand Unit

This unit carries out one in-place update of a memory operand on behalf of a processor core. The operand is 8 or 16 bits wide. The unit supports eight updates: shift left, shift right, rotate left through carry, rotate right through carry, increment, decrement, test-and-set-bits and test-and-clear-bits. The core supplies the operation, the width, the operand address, the accumulator and the incoming carry and negative flags, then pulses `start`. The unit fetches the operand one byte at a time over a single-byte memory port. It spends one internal cycle computing the new value and the flags, then stores the result back over the same port.

Each port transfer uses a request/ready handshake. A transfer completes on a clock edge where `mem_req` and `mem_ready` are both high. The unit keeps an open-bus latch holding the last byte that moved across the port in either direction. It also presents the carry, zero and negative flags that result from the operation. Address generation and any wrap rules beyond simple modular addition belong to the surrounding core.

Top module: `rmw_unit`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `mem_req` are low, and `open_bus`, `carry_out`, `zero_out` and `neg_out` are zero.
- R2: For an 8-bit operation (`wide`=0) the port sees, in order: a read at the base address, exactly one busy cycle with no request, then a write to the base address. For a 16-bit operation (`wide`=1) the order is: read low byte at base, read high byte at base+1 (modulo 2^ADDR_W), one busy cycle with no request, write high byte at base+1, then write low byte at base.
- R3: While `mem_req` is high and `mem_ready` is low, the request stays high and `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R4: `done` is high for exactly the one cycle after the final write is accepted, and `busy` is low in that cycle. A `start` seen while `busy` is high has no effect: it produces no transfers and no extra `done`.
- R5: `open_bus` holds the last byte transferred on the port, whether read or written, from the cycle after the transfer. After completion it therefore equals the low byte of the result.
- R6: Code 0 shifts left and code 1 shifts right, filling with zero. The carry becomes the old top bit for the left shift and the old bit 0 for the right shift.
- R7: Code 2 rotates left, putting `carry_in` into bit 0, and code 3 rotates right, putting `carry_in` into the top bit. The carry becomes the bit shifted out.
- R8: Code 4 adds one and code 5 subtracts one, wrapping at the operand width. `carry_out` equals `carry_in`.
- R9: Code 6 ORs the accumulator into the operand and code 7 ANDs the operand with the inverted accumulator. `zero_out` is 1 when operand AND accumulator (taken before the update) is zero. `neg_out` equals `neg_in`, and `carry_out` equals `carry_in`.
- R10: For codes 0 to 5, `zero_out` is 1 when the width-masked result is zero and `neg_out` is the result's top bit (bit 7 or bit 15). In 8-bit mode the upper accumulator byte has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation code, 0 to 7 |
| wide | input | 1 | 1 for a 16-bit operand, 0 for 8-bit |
| base_addr | input | ADDR_W | Address of the operand's low byte |
| acc | input | 2*BYTE_W | Accumulator used by codes 6 and 7 |
| carry_in | input | 1 | Carry before the operation |
| neg_in | input | 1 | Negative flag before the operation |
| mem_req | output | 1 | Transfer request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Transfer address |
| mem_wdata | output | BYTE_W | Write byte |
| mem_rdata | input | BYTE_W | Read byte, valid with mem_ready |
| mem_ready | input | 1 | Transfer accepted this edge |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry_out | output | 1 | Resulting carry |
| zero_out | output | 1 | Resulting zero flag |
| neg_out | output | 1 | Resulting negative flag |
| open_bus | output | BYTE_W | Last byte seen on the port |

## Verification
The bench builds the unit with ADDR_W=8 and BYTE_W=8. The narrow address lets a 16-bit operand placed at address 0xFF split across the top and bottom of the space, which exercises the base+1 wrap. A 256-byte array then models the whole memory. With 8-bit bytes, every code can be driven to its carry-out, zero and sign corners from a few chosen values. A pseudo-random ready pattern adds stall cycles in every state of the handshake.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_ROL  = 3'd2,
    OP_ROR  = 3'd3,
    OP_INC  = 3'd4,
    OP_DEC  = 3'd5,
    OP_TSET = 3'd6,
    OP_TCLR = 3'd7
  } rmw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD_LO = 3'd1,
    ST_RD_HI = 3'd2,
    ST_MOD   = 3'd3,
    ST_WR_HI = 3'd4,
    ST_WR_LO = 3'd5
  } rmw_state_e;

endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  rmw_op_e                 op,
  input  logic                    wide,
  input  logic [2*BYTE_W-1:0]     operand,
  input  logic [2*BYTE_W-1:0]     acc,
  input  logic                    cin,
  input  logic                    nin,
  output logic [2*BYTE_W-1:0]     result,
  output logic                    cout,
  output logic                    zout,
  output logic                    nout
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] mask, topmask, opm, accm, res;
  logic              top_old;

  always_comb begin
    mask    = wide ? {WORD_W{1'b1}} : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
    topmask = wide ? (WORD_W'(1) << (WORD_W - 1)) : (WORD_W'(1) << (BYTE_W - 1));
    opm     = operand & mask;
    accm    = acc & mask;
    top_old = |(opm & topmask);
    res     = '0;
    cout    = cin;
    case (op)
      OP_SHL:  begin res = opm << 1; cout = top_old; end
      OP_SHR:  begin res = opm >> 1; cout = opm[0]; end
      OP_ROL:  begin res = (opm << 1) | WORD_W'(cin); cout = top_old; end
      OP_ROR:  begin res = (opm >> 1) | (cin ? topmask : '0); cout = opm[0]; end
      OP_INC:  res = opm + WORD_W'(1);
      OP_DEC:  res = opm - WORD_W'(1);
      OP_TSET: res = opm | accm;
      OP_TCLR: res = opm & ~accm;
      default: res = opm;
    endcase
    res = res & mask;
    if (op == OP_TSET || op == OP_TCLR) begin
      zout = ((opm & accm) == '0);
      nout = nin;
    end else begin
      zout = (res == '0);
      nout = |(res & topmask);
    end
    result = res;
  end

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  rmw_op_e             op_i,
  input  logic                wide_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [2*BYTE_W-1:0] acc_i,
  input  logic                cin_i,
  input  logic                nin_i,
  input  logic [2*BYTE_W-1:0] alu_res_i,
  input  logic                mem_ready,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic                busy,
  output logic                done,
  output logic [BYTE_W-1:0]   open_bus,
  output logic                mod_stb,
  output rmw_op_e             op_q,
  output logic                wide_q,
  output logic [2*BYTE_W-1:0] opnd_q,
  output logic [2*BYTE_W-1:0] acc_q,
  output logic                cin_q,
  output logic                nin_q
);
  localparam int WORD_W = 2 * BYTE_W;

  rmw_state_e          state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [ADDR_W-1:0]   addr_hi;
  logic [WORD_W-1:0]   res_q;
  logic [BYTE_W-1:0]   obus_q;
  logic                done_q;

  assign addr_hi = addr_q + ADDR_W'(1);

  always_comb begin
    mem_req   = (state_q == ST_RD_LO) || (state_q == ST_RD_HI) ||
                (state_q == ST_WR_HI) || (state_q == ST_WR_LO);
    mem_we    = (state_q == ST_WR_HI) || (state_q == ST_WR_LO);
    mem_addr  = ((state_q == ST_RD_HI) || (state_q == ST_WR_HI)) ? addr_hi : addr_q;
    mem_wdata = (state_q == ST_WR_HI) ? res_q[WORD_W-1:BYTE_W] : res_q[BYTE_W-1:0];
    busy      = (state_q != ST_IDLE);
    mod_stb   = (state_q == ST_MOD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      res_q   <= '0;
      obus_q  <= '0;
      done_q  <= 1'b0;
      op_q    <= OP_SHL;
      wide_q  <= 1'b0;
      opnd_q  <= '0;
      acc_q   <= '0;
      cin_q   <= 1'b0;
      nin_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          op_q    <= op_i;
          wide_q  <= wide_i;
          addr_q  <= base_i;
          acc_q   <= acc_i;
          cin_q   <= cin_i;
          nin_q   <= nin_i;
          opnd_q  <= '0;
          state_q <= ST_RD_LO;
        end
        ST_RD_LO: if (mem_ready) begin
          opnd_q[BYTE_W-1:0] <= mem_rdata;
          obus_q             <= mem_rdata;
          state_q            <= wide_q ? ST_RD_HI : ST_MOD;
        end
        ST_RD_HI: if (mem_ready) begin
          opnd_q[WORD_W-1:BYTE_W] <= mem_rdata;
          obus_q                  <= mem_rdata;
          state_q                 <= ST_MOD;
        end
        ST_MOD: begin
          res_q   <= alu_res_i;
          state_q <= wide_q ? ST_WR_HI : ST_WR_LO;
        end
        ST_WR_HI: if (mem_ready) begin
          obus_q  <= mem_wdata;
          state_q <= ST_WR_LO;
        end
        ST_WR_LO: if (mem_ready) begin
          obus_q  <= mem_wdata;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done     = done_q;
  assign open_bus = obus_q;

endmodule

// File: rtl/rmw_unit.sv
module rmw_unit
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [2:0]          op,
  input  logic                wide,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [2*BYTE_W-1:0] acc,
  input  logic                carry_in,
  input  logic                neg_in,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  input  logic [BYTE_W-1:0]   mem_rdata,
  input  logic                mem_ready,
  output logic                busy,
  output logic                done,
  output logic                carry_out,
  output logic                zero_out,
  output logic                neg_out,
  output logic [BYTE_W-1:0]   open_bus
);
  localparam int WORD_W = 2 * BYTE_W;

  rmw_op_e           op_q;
  logic              wide_q, cin_q, nin_q, mod_stb;
  logic [WORD_W-1:0] opnd_q, acc_q, alu_res;
  logic              alu_c, alu_z, alu_n;
  logic              c_q, z_q, n_q;

  rmw_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op_i      (rmw_op_e'(op)),
    .wide_i    (wide),
    .base_i    (base_addr),
    .acc_i     (acc),
    .cin_i     (carry_in),
    .nin_i     (neg_in),
    .alu_res_i (alu_res),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .open_bus  (open_bus),
    .mod_stb   (mod_stb),
    .op_q      (op_q),
    .wide_q    (wide_q),
    .opnd_q    (opnd_q),
    .acc_q     (acc_q),
    .cin_q     (cin_q),
    .nin_q     (nin_q)
  );

  rmw_alu #(.BYTE_W(BYTE_W)) u_alu (
    .op      (op_q),
    .wide    (wide_q),
    .operand (opnd_q),
    .acc     (acc_q),
    .cin     (cin_q),
    .nin     (nin_q),
    .result  (alu_res),
    .cout    (alu_c),
    .zout    (alu_z),
    .nout    (alu_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
      n_q <= 1'b0;
    end else if (mod_stb) begin
      c_q <= alu_c;
      z_q <= alu_z;
      n_q <= alu_n;
    end
  end

  assign carry_out = c_q;
  assign zero_out  = z_q;
  assign neg_out   = n_q;

endmodule

// File: rtl/rmw_unit_chk.sv
module rmw_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [BYTE_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic              busy,
  input logic              done,
  input logic [BYTE_W-1:0] open_bus
);

  assert_hold_req_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_idle_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !$past(mem_req && mem_we)) |-> !$past(mem_req));

  assert_req_busy_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_done_after_write_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(mem_req && mem_we && mem_ready) && !busy));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_openbus_final_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (open_bus == $past(mem_wdata)));

endmodule

bind rmw_unit rmw_unit_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .busy      (busy),
  .done      (done),
  .open_bus  (open_bus)
);

// File: tb/test_rmw_unit.sv
module test_rmw_unit;
  localparam int AW = 8;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [2:0]    op = '0;
  logic          wide = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [15:0]   acc = '0;
  logic          carry_in = 1'b0;
  logic          neg_in = 1'b0;
  logic          mem_req, mem_we, busy, done, carry_out, zero_out, neg_out;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] mem_wdata, mem_rdata, open_bus;
  logic          mem_ready = 1'b1;

  logic [7:0] bmem [0:255];
  assign mem_rdata = bmem[mem_addr];

  always #5 clk = ~clk;

  rmw_unit #(.ADDR_W(AW), .BYTE_W(BW)) i_rmw_unit (
    .clk(clk), .rst(rst), .start(start), .op(op), .wide(wide),
    .base_addr(base_addr), .acc(acc), .carry_in(carry_in), .neg_in(neg_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .carry_out(carry_out), .zero_out(zero_out),
    .neg_out(neg_out), .open_bus(open_bus)
  );

  int compared = 0;
  int mismatched = 0;
  int q_addr[$];
  int q_we[$];
  int q_dat[$];
  int exp_obus = 0;
  int exp_done_next = 0;
  int exp_c, exp_z, exp_n;
  int gap = 0;
  int op_done = 0;
  string cur_tag = "R6";
  bit rnd_ready = 1'b0;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input string tag, input int act, input int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    #2;
    if (rnd_ready) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      mem_ready = ((seed >> 16) & 3) != 0;
    end else begin
      mem_ready = 1'b1;
    end
  end

  // Cycle-by-cycle reference comparison, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 open bus", int'(open_bus), exp_obus);
      chk("R4 done", int'(done), exp_done_next);
      if (done) begin
        chk({cur_tag, " carry"}, int'(carry_out), exp_c);
        chk({cur_tag, " R10 zero"}, int'(zero_out), exp_z);
        chk({cur_tag, " R10 neg"}, int'(neg_out), exp_n);
        chk("R2 idle modify cycles", gap, 1);
        gap = 0;
        op_done = 1;
      end
      exp_done_next = 0;
      if (busy && !mem_req) gap++;
      if (mem_req && mem_ready) begin
        if (q_addr.size() == 0) begin
          chk("R4 unexpected transfer", 1, 0);
        end else begin
          int a, w, d;
          a = q_addr.pop_front();
          w = q_we.pop_front();
          d = q_dat.pop_front();
          chk("R2/R3 address", int'(mem_addr), a);
          chk("R2 direction", int'(mem_we), w);
          if (w != 0) chk("R2 write data", int'(mem_wdata), d);
          if (q_addr.size() == 0) exp_done_next = 1;
        end
        if (mem_we) begin
          bmem[mem_addr] = mem_wdata;
          exp_obus = int'(mem_wdata);
        end else begin
          exp_obus = int'(mem_rdata);
        end
      end
    end
  end

  task automatic run_op(input int o, input int w, input int a, input int ac,
                        input int ci, input int ni, input bit junk);
    int msk, topb, opv, av, res, c, z, n, hi_a, guard;
    msk  = w ? 'hFFFF : 'hFF;
    topb = w ? 'h8000 : 'h80;
    hi_a = (a + 1) & 'hFF;
    opv  = int'(bmem[a]) | (w ? (int'(bmem[hi_a]) << 8) : 0);
    av   = ac & msk;
    c    = ci;
    case (o)
      0: begin res = (opv << 1) & msk; c = ((opv & topb) != 0) ? 1 : 0; end
      1: begin res = opv >> 1; c = opv & 1; end
      2: begin res = ((opv << 1) | ci) & msk; c = ((opv & topb) != 0) ? 1 : 0; end
      3: begin res = (opv >> 1) | (ci != 0 ? topb : 0); c = opv & 1; end
      4: res = (opv + 1) & msk;
      5: res = (opv - 1) & msk;
      6: res = opv | av;
      default: res = opv & ~av & msk;
    endcase
    if (o >= 6) begin
      z = ((opv & av) == 0) ? 1 : 0;
      n = ni;
    end else begin
      z = (res == 0) ? 1 : 0;
      n = ((res & topb) != 0) ? 1 : 0;
    end
    exp_c = c; exp_z = z; exp_n = n;
    cur_tag = (o < 2) ? "R6" : (o < 4) ? "R7" : (o < 6) ? "R8" : "R9";
    q_addr.push_back(a); q_we.push_back(0); q_dat.push_back(0);
    if (w != 0) begin
      q_addr.push_back(hi_a); q_we.push_back(0); q_dat.push_back(0);
      q_addr.push_back(hi_a); q_we.push_back(1); q_dat.push_back((res >> 8) & 'hFF);
    end
    q_addr.push_back(a); q_we.push_back(1); q_dat.push_back(res & 'hFF);
    op_done = 0;
    @(posedge clk); #2;
    start = 1'b1; op = 3'(o); wide = w[0]; base_addr = AW'(a);
    acc = 16'(ac); carry_in = ci[0]; neg_in = ni[0];
    @(posedge clk); #2;
    if (junk) begin
      // R4: start pulses while busy must be ignored
      op = 3'(7 - o); wide = ~wide; base_addr = base_addr + 8'd9;
      repeat (3) @(posedge clk);
      #2;
    end
    start = 1'b0;
    guard = 0;
    while (op_done == 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (op_done == 0) chk("R4 completion timeout", 0, 1);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 0, 1);
    report();
  end

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'(i * 37 + 5);
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 mem_req", int'(mem_req), 0);
    chk("R1 open_bus", int'(open_bus), 0);
    chk("R1 flags", int'({carry_out, zero_out, neg_out}), 0);

    bmem[8'h10] = 8'h81;                 run_op(0, 0, 'h10, 0, 0, 0, 0);       // R6 shl
    bmem[8'h20] = 8'h01; bmem[8'h21] = 8'h00; run_op(1, 1, 'h20, 0, 0, 0, 0);  // R6 shr to zero
    bmem[8'h30] = 8'h80;                 run_op(2, 0, 'h30, 0, 1, 0, 0);       // R7 rol
    bmem[8'h40] = 8'h02; bmem[8'h41] = 8'h00; run_op(3, 1, 'h40, 0, 1, 0, 0);  // R7 ror
    bmem[8'h50] = 8'hFF;                 run_op(4, 0, 'h50, 0, 1, 0, 0);       // R8 inc wrap
    bmem[8'h60] = 8'h00; bmem[8'h61] = 8'h00; run_op(5, 1, 'h60, 0, 0, 1, 0);  // R8 dec wrap
    bmem[8'h70] = 8'hF0;                 run_op(6, 0, 'h70, 'hAB0F, 0, 1, 0);  // R9/R10 set, acc high ignored
    bmem[8'h80] = 8'hFF; bmem[8'h81] = 8'h12; run_op(7, 1, 'h80, 'h00FF, 1, 0, 0); // R9 clear
    bmem[8'hFF] = 8'h34; bmem[8'h00] = 8'h92; run_op(0, 1, 'hFF, 0, 0, 0, 0);  // R2 address wrap
    bmem[8'h90] = 8'h7F;                 run_op(4, 0, 'h90, 0, 0, 0, 1);       // R4 ignored start
    bmem[8'hA0] = 8'h00; bmem[8'hA1] = 8'h80; run_op(2, 1, 'hA0, 0, 0, 0, 1);  // R4 ignored start, wide

    // R3 handshake under stalls, all codes and widths
    rnd_ready = 1'b1;
    for (int k = 0; k < 80; k++) begin
      seed = seed * 32'd69069 + 32'd1;
      run_op(int'((seed >> 8) & 7), int'((seed >> 11) & 1), int'((seed >> 12) & 'hFF),
             int'((seed >> 3) & 'hFFFF), int'((seed >> 20) & 1), int'((seed >> 21) & 1), 0);
    end
    rnd_ready = 1'b0;
    repeat (4) @(posedge clk);
    chk("R4 no leftover transfers", q_addr.size(), 0);
    report();
  end

endmodule